// File: doc/BRIEF.md
# CPU Bus Address Router

This block sits between a byte-wide CPU with a 16-bit address and the memories and register groups around it. Each request is decoded by address range into exactly one target. The block then raises that target's strobe for one cycle and presents the forwarded address, the write data and the direction. In the same cycle it returns the byte read from the selected target. The targets are:

- the cartridge port
- work RAM, with its bank-select register and a mirror window
- video RAM
- sprite attribute memory
- three peripheral register groups
- the interrupt registers
- an input-port register
- a local scratch byte store, which catches every address that no other target claims

The input-port register and the scratch store live inside the block. All other targets are outside it and answer through the read-data bus.

A 16-bit request is split into two byte accesses on consecutive cycles: the low byte at the given address, then the high byte at the next address. The address wraps at 64 Ki. While the second byte is in flight, the block raises `busy` and ignores its request inputs. For a word read, it assembles the two bytes into one 16-bit result.

Top module: `mmap_router`

## Requirements
- R1: Addresses 0x0000–0x7FFF and 0xA000–0xBFFF select the cartridge port, with the address forwarded unchanged.
- R2: Addresses 0xC000–0xDFFF and the bank-select register at 0xFF70 select work RAM, with the address forwarded unchanged.
- R3: Addresses 0xE000–0xFDFF select work RAM. The forwarded address is 0xC000 + ((addr − 0xE000) & 0x1FFF).
- R4: Addresses 0x8000–0x9FFF select video RAM, and addresses 0xFE00–0xFE9F select sprite attribute memory.
- R5: Addresses 0xFFFF and 0xFF0F select the interrupt target. This holds even though 0xFF0F lies inside peripheral group 0.
- R6: The peripheral groups are decoded as follows: group 0 is 0xFF01–0xFF0F, group 1 is 0xFF10–0xFF3F and group 2 is 0xFF40–0xFF6F.
- R7: The input-port register sits at 0xFF00 and resets to 0xCF. A write replaces bits 7:4 only; bits 3:0 keep their value.
- R8: Every other address reaches the scratch store, which reads back the last byte written there. With the default 9-bit index, every unclaimed address maps to its own byte.
- R9: One cycle after a valid request, exactly one strobe bit is high; with no request, no bit is high. Strobe bit indices are: cartridge 0, work RAM 1, video RAM 2, sprite memory 3, interrupt 4, group 0 5, group 1 6, group 2 7, input port 8, scratch 9.
- R10: In a read's strobe cycle, `rd_valid` is high and `rd_data` carries the byte of the selected target. For the external targets, that byte is the matching slice of `ext_rdata`.
- R11: A wide request issues the low byte at addr and, one cycle later, the high byte at (addr+1) mod 65536. `busy` is high in the cycle between the two issues. On a read, `word_data` = {high byte, low byte} is valid with the second strobe.
- R12: Request inputs presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_wide | input | 1 | 16-bit request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data (low byte used for byte requests) |
| busy | output | 1 | Second byte of a wide request in flight |
| sel | output | 10 | One-hot target strobe |
| tgt_wr | output | 1 | Direction of the strobed access |
| tgt_addr | output | 16 | Forwarded address |
| tgt_wdata | output | 8 | Byte to write |
| ext_rdata | input | 64 | Read bytes of the eight external targets, target i at bits 8i+7:8i |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 8 | Read response byte |
| word_valid | output | 1 | Assembled wide read present |
| word_data | output | 16 | Assembled wide read |

## Verification
The bench probes the first and last byte of every range, where an off-by-one bound would hand the access to a neighbour. It checks the mirror window's edges, where a missing fold would send the raw mirror address to work RAM. It also checks 0xFF0F, where a wrong priority would strobe peripheral group 0 instead of the interrupt target. A wide read at 0xFFFF must wrap to 0x0000; a design without the wrap would carry into a seventeenth bit or re-read 0xFFFF. A write offered while `busy` is high must not land in the scratch store. The input-port write must keep its low nibble: a full-byte write would read back 0x35 instead of 0x3F.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int N_TGT = 10;
  localparam int N_EXT = 8;

  typedef enum logic [3:0] {
    T_CART    = 4'd0,
    T_WRAM    = 4'd1,
    T_VRAM    = 4'd2,
    T_OAM     = 4'd3,
    T_INTR    = 4'd4,
    T_PER0    = 4'd5,
    T_PER1    = 4'd6,
    T_PER2    = 4'd7,
    T_INPORT  = 4'd8,
    T_SCRATCH = 4'd9
  } tgt_e;

  localparam logic [15:0] WRAM_BASE   = 16'hC000;
  localparam logic [15:0] WRAM_FOLD   = 16'h1FFF;
  localparam logic [15:0] MIRROR_LO   = 16'hE000;
  localparam logic [15:0] MIRROR_HI   = 16'hFDFF;
  localparam logic [15:0] BANK_REG    = 16'hFF70;
  localparam logic [15:0] IRQ_EN_ADR  = 16'hFFFF;
  localparam logic [15:0] IRQ_FLG_ADR = 16'hFF0F;
  localparam logic [15:0] INPORT_ADR  = 16'hFF00;

  typedef struct packed {
    logic        valid;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        first;   // low byte of a wide request
    logic        second;  // high byte of a wide request
  } byte_req_t;

  function automatic logic in_rng(input logic [15:0] a, input logic [15:0] lo,
                                  input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/mmap_split.sv
module mmap_split
  import mmap_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_wide,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [2*DW-1:0] req_wdata,
  output logic          busy,
  output byte_req_t     iss
);
  logic          hi_pend;
  logic [AW-1:0] hi_addr;
  logic [DW-1:0] hi_data;
  logic          hi_wr;

  always_comb begin
    if (hi_pend) begin
      iss = '{valid: 1'b1, wr: hi_wr, addr: hi_addr, wdata: hi_data,
              first: 1'b0, second: 1'b1};
    end else begin
      iss = '{valid: req_valid, wr: req_wr, addr: req_addr,
              wdata: req_wdata[DW-1:0], first: req_valid & req_wide,
              second: 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pend <= 1'b0;
      hi_addr <= '0;
      hi_data <= '0;
      hi_wr   <= 1'b0;
    end else if (hi_pend) begin
      hi_pend <= 1'b0;
    end else if (req_valid && req_wide) begin
      hi_pend <= 1'b1;
      hi_addr <= req_addr + AW'(1);
      hi_data <= req_wdata[2*DW-1:DW];
      hi_wr   <= req_wr;
    end
  end

  assign busy = hi_pend;

  // R11: the high byte occupies exactly one cycle
  a_r11_single_hi: assert property (@(posedge clk) disable iff (rst)
    hi_pend |=> !hi_pend);
  // R11: the high byte goes to the next address, wrapping
  a_r11_hi_addr: assert property (@(posedge clk) disable iff (rst)
    hi_pend |-> (iss.addr == $past(req_addr) + AW'(1)));
endmodule

// File: rtl/mmap_decode.sv
module mmap_decode
  import mmap_pkg::*;
(
  input  logic [15:0] addr,
  output tgt_e        tgt,
  output logic [15:0] fwd
);
  always_comb begin
    fwd = addr;
    if (in_rng(addr, 16'h0000, 16'h7FFF) || in_rng(addr, 16'hA000, 16'hBFFF)) begin
      tgt = T_CART;
    end else if (in_rng(addr, 16'hC000, 16'hDFFF) || addr == BANK_REG) begin
      tgt = T_WRAM;
    end else if (in_rng(addr, MIRROR_LO, MIRROR_HI)) begin
      tgt = T_WRAM;
      fwd = WRAM_BASE + ((addr - MIRROR_LO) & WRAM_FOLD);
    end else if (addr == IRQ_EN_ADR || addr == IRQ_FLG_ADR) begin
      tgt = T_INTR;
    end else if (in_rng(addr, 16'h8000, 16'h9FFF)) begin
      tgt = T_VRAM;
    end else if (in_rng(addr, 16'hFE00, 16'hFE9F)) begin
      tgt = T_OAM;
    end else if (in_rng(addr, 16'hFF01, 16'hFF0F)) begin
      tgt = T_PER0;
    end else if (in_rng(addr, 16'hFF10, 16'hFF3F)) begin
      tgt = T_PER1;
    end else if (in_rng(addr, 16'hFF40, 16'hFF6F)) begin
      tgt = T_PER2;
    end else if (addr == INPORT_ADR) begin
      tgt = T_INPORT;
    end else begin
      tgt = T_SCRATCH;
    end
  end
endmodule

// File: rtl/mmap_scratch.sv
module mmap_scratch #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mmap_router.sv
module mmap_router
  import mmap_pkg::*;
#(
  parameter int          SCR_AW     = 9,
  parameter logic [7:0]  INPORT_RST = 8'hCF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_wide,
  input  logic                 req_wr,
  input  logic [15:0]          req_addr,
  input  logic [15:0]          req_wdata,
  output logic                 busy,
  output logic [N_TGT-1:0]     sel,
  output logic                 tgt_wr,
  output logic [15:0]          tgt_addr,
  output logic [7:0]           tgt_wdata,
  input  logic [N_EXT*8-1:0]   ext_rdata,
  output logic                 rd_valid,
  output logic [7:0]           rd_data,
  output logic                 word_valid,
  output logic [15:0]          word_data
);
  byte_req_t        iss;
  tgt_e             dec_tgt;
  logic [15:0]      dec_fwd;
  logic [N_TGT-1:0] dec_oh;
  logic             first_q, second_q;
  logic [7:0]       inport_q;
  logic [7:0]       scr_rd;
  logic [7:0]       lo_q;
  logic [7:0]       rd_mux;
  logic             scr_we;

  mmap_split #(.AW(16), .DW(8)) split_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_wide(req_wide),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .iss(iss)
  );

  mmap_decode decode_i (.addr(iss.addr), .tgt(dec_tgt), .fwd(dec_fwd));

  for (genvar g = 0; g < N_TGT; g++) begin : g_oh
    assign dec_oh[g] = (dec_tgt == tgt_e'(g));
  end

  assign scr_we = iss.valid && iss.wr && (dec_tgt == T_SCRATCH);

  mmap_scratch #(.AW(SCR_AW), .DW(8)) scratch_i (
    .clk(clk), .we(scr_we), .addr(dec_fwd[SCR_AW-1:0]),
    .wdata(iss.wdata), .rdata(scr_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= '0;
      tgt_wr    <= 1'b0;
      tgt_addr  <= '0;
      tgt_wdata <= '0;
      first_q   <= 1'b0;
      second_q  <= 1'b0;
    end else begin
      sel       <= iss.valid ? dec_oh : '0;
      tgt_wr    <= iss.valid & iss.wr;
      tgt_addr  <= dec_fwd;
      tgt_wdata <= iss.wdata;
      first_q   <= iss.valid & iss.first;
      second_q  <= iss.valid & iss.second;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inport_q <= INPORT_RST;
    end else if (iss.valid && iss.wr && dec_tgt == T_INPORT) begin
      inport_q <= {iss.wdata[7:4], inport_q[3:0]};
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_EXT; i++) begin
      if (sel[i]) rd_mux = rd_mux | ext_rdata[i*8 +: 8];
    end
    if (sel[T_INPORT])  rd_mux = rd_mux | inport_q;
    if (sel[T_SCRATCH]) rd_mux = rd_mux | scr_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) lo_q <= '0;
    else if (rd_valid && first_q) lo_q <= rd_mux;
  end

  assign rd_valid   = (|sel) & ~tgt_wr;
  assign rd_data    = rd_mux;
  assign word_valid = rd_valid & second_q;
  assign word_data  = {rd_mux, lo_q};

  // R9: never more than one strobe
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  // R9: a strobe only follows an issued byte
  a_r9_follows: assert property (@(posedge clk) disable iff (rst)
    (|sel) |-> $past(iss.valid));
  // R3: work RAM only ever sees its own window or the bank register
  a_r3_wram_window: assert property (@(posedge clk) disable iff (rst)
    sel[T_WRAM] |-> (tgt_addr[15:13] == 3'b110 || tgt_addr == BANK_REG));
  // R7: low nibble of the input port never changes
  a_r7_lo_keep: assert property (@(posedge clk) disable iff (rst)
    $stable(inport_q[3:0]));
  // R11: an assembled word follows a low-byte read response
  a_r11_word: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(rd_valid));
endmodule

// File: tb/mmap_router_tb.sv
module mmap_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_wide = 1'b0, req_wr = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy;
  logic [9:0]  sel;
  logic        tgt_wr;
  logic [15:0] tgt_addr;
  logic [7:0]  tgt_wdata;
  logic [63:0] ext_rdata;
  logic        rd_valid, word_valid;
  logic [7:0]  rd_data;
  logic [15:0] word_data;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mmap_router dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_wide(req_wide),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .sel(sel), .tgt_wr(tgt_wr), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .ext_rdata(ext_rdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .word_valid(word_valid), .word_data(word_data)
  );

  function automatic logic [7:0] stub(input int t, input logic [15:0] a);
    return (a[7:0] ^ a[15:8]) + 8'(t * 37);
  endfunction

  for (genvar g = 0; g < 8; g++) begin : g_stub
    assign ext_rdata[g*8 +: 8] = stub(g, tgt_addr);
  end

  // {address, expected target, expected forwarded address}
  localparam int NV = 26;
  localparam logic [35:0] VEC [NV] = '{
    {16'h0000, 4'd0, 16'h0000}, {16'h7FFF, 4'd0, 16'h7FFF},
    {16'hA000, 4'd0, 16'hA000}, {16'hBFFF, 4'd0, 16'hBFFF},
    {16'h8000, 4'd2, 16'h8000}, {16'h9FFF, 4'd2, 16'h9FFF},
    {16'hC000, 4'd1, 16'hC000}, {16'hDFFF, 4'd1, 16'hDFFF},
    {16'hE000, 4'd1, 16'hC000}, {16'hFDFF, 4'd1, 16'hDDFF},
    {16'hE123, 4'd1, 16'hC123}, {16'hFE00, 4'd3, 16'hFE00},
    {16'hFE9F, 4'd3, 16'hFE9F}, {16'hFEA0, 4'd9, 16'hFEA0},
    {16'hFF00, 4'd8, 16'hFF00}, {16'hFF01, 4'd5, 16'hFF01},
    {16'hFF0F, 4'd4, 16'hFF0F}, {16'hFF10, 4'd6, 16'hFF10},
    {16'hFF3F, 4'd6, 16'hFF3F}, {16'hFF40, 4'd7, 16'hFF40},
    {16'hFF6F, 4'd7, 16'hFF6F}, {16'hFF70, 4'd1, 16'hFF70},
    {16'hFF71, 4'd9, 16'hFF71}, {16'hFF80, 4'd9, 16'hFF80},
    {16'hFFFE, 4'd9, 16'hFFFE}, {16'hFFFF, 4'd4, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a negedge, return at the next negedge with the response visible
  task automatic acc(input logic wide, input logic wr, input logic [15:0] a,
                     input logic [15:0] d);
    req_valid = 1'b1; req_wide = wide; req_wr = wr; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_wide = 1'b0;
  endtask

  task automatic rd_byte(input string req, input logic [15:0] a, input logic [7:0] exp);
    acc(1'b0, 1'b0, a, 16'h0);
    chk(req, {31'b0, rd_valid}, 32'd1);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset sel", sel, 0);
    chk("R11 reset busy", busy, 0);
    chk("R10 reset rd_valid", rd_valid, 0);

    // R1 R2 R3 R4 R5 R6 R9 R10: decode table
    for (int i = 0; i < NV; i++) begin
      logic [15:0] a, f;
      logic [3:0]  t;
      {a, t, f} = VEC[i];
      acc(1'b0, 1'b0, a, 16'h0);
      chk($sformatf("R1-6 route %h sel (R9)", a), sel, 32'(10'(1) << t));
      chk($sformatf("R3 fwd %h", a), tgt_addr, f);
      if (t < 4'd8) chk($sformatf("R10 rdata %h", a), rd_data, stub(int'(t), f));
    end
    @(negedge clk);
    chk("R9 idle no strobe", sel, 0);

    // R7: input port
    rd_byte("R7 reset value", 16'hFF00, 8'hCF);
    acc(1'b0, 1'b1, 16'hFF00, 16'h0035);
    chk("R7 write strobe", sel, 32'h100);
    rd_byte("R7 upper nibble only", 16'hFF00, 8'h3F);
    acc(1'b0, 1'b1, 16'hFF00, 16'h00A0);
    rd_byte("R7 second write", 16'hFF00, 8'hAF);

    // R8: scratch store
    acc(1'b0, 1'b1, 16'hFF80, 16'h005A);
    acc(1'b0, 1'b1, 16'hFFFE, 16'h00C3);
    acc(1'b0, 1'b1, 16'hFEA0, 16'h0011);
    acc(1'b0, 1'b1, 16'hFF90, 16'h0012);
    rd_byte("R8 scratch FF80", 16'hFF80, 8'h5A);
    rd_byte("R8 scratch FFFE", 16'hFFFE, 8'hC3);
    rd_byte("R8 scratch FEA0", 16'hFEA0, 8'h11);

    // R3: mirrored write
    acc(1'b0, 1'b1, 16'hE010, 16'h0066);
    chk("R3 mirror write sel", sel, 32'h2);
    chk("R3 mirror write addr", tgt_addr, 16'hC010);
    chk("R3 mirror write data", tgt_wdata, 8'h66);
    chk("R3 mirror write dir", tgt_wr, 1);

    // R11 R12: wide read with an ignored request during busy
    acc(1'b1, 1'b0, 16'hC100, 16'h0);
    chk("R11 busy", busy, 1);
    chk("R11 low sel", sel, 32'h2);
    chk("R11 low byte", rd_data, stub(1, 16'hC100));
    req_valid = 1'b1; req_wr = 1'b1; req_addr = 16'hFF90; req_wdata = 16'h0077;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_wr = 1'b0;
    chk("R11 high addr", tgt_addr, 16'hC101);
    chk("R12 high not replaced", tgt_wr, 0);
    chk("R11 word valid", word_valid, 1);
    chk("R11 word data", word_data, {stub(1, 16'hC101), stub(1, 16'hC100)});
    @(negedge clk);
    chk("R11 busy cleared", busy, 0);
    rd_byte("R12 ignored write left scratch", 16'hFF90, 8'h12);

    // R11: wrap at the top of the space
    acc(1'b1, 1'b0, 16'hFFFF, 16'h0);
    chk("R11 wrap low sel", sel, 32'h10);
    @(posedge clk); @(negedge clk);
    chk("R11 wrap high sel", sel, 32'h1);
    chk("R11 wrap high addr", tgt_addr, 16'h0000);
    chk("R11 wrap word", word_data, {stub(0, 16'h0000), stub(4, 16'hFFFF)});

    // R11: wide write into scratch
    acc(1'b1, 1'b1, 16'hFF80, 16'hBEEF);
    chk("R11 wide write low data", tgt_wdata, 8'hEF);
    @(posedge clk); @(negedge clk);
    chk("R11 wide write high addr", tgt_addr, 16'hFF81);
    chk("R11 wide write high data", tgt_wdata, 8'hBE);
    @(negedge clk);
    rd_byte("R11 wide write low readback", 16'hFF80, 8'hEF);
    rd_byte("R11 wide write high readback", 16'hFF81, 8'hBE);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule